// File: doc/BRIEF.md
# Horizontal Drive Soft-Start Sequencer

This block makes the horizontal output drive pulse for a deflection stage and controls how that pulse comes up and goes down. A line-start strobe marks the start of each line. Inside a line the drive stays low for a fixed nominal OFF interval and then goes high for an ON interval. At power-up the ON interval grows by one step per line from zero to its nominal width, and the OFF interval never changes. At shutdown the ON interval shrinks the same way, one step per line. After the upward ramp ends and the supply-good status is present, the sequencer enters its running state. In that state the drive is masked whenever flyback is high.

Control comes through a small write port. Its bits are a standby-enable, a protection-disable, and write-one-to-clear strobes for two sticky flags: a power-on flag and an over-voltage flag. The drive can start only when standby-enable is set and both flags are clear.

Two protection inputs act on the sequence:
- An over-voltage input always sets the over-voltage flag. When protection-disable is set, it also clears standby-enable and ramps the drive down.
- A flash input cuts the drive at once. When flash is released, the drive restarts through the upward ramp.

Top module: `hdrv_softstart`

## Requirements
- R1: After synchronous reset the drive output is low, the power-on flag reads 1, the over-voltage flag reads 0, and standby-enable and protection-disable read 0.
- R2: The drive stays low for as long as the power-on flag is set, the over-voltage flag is set, or standby-enable is clear.
- R3: During the upward ramp, each line begins with a low interval of T_OFF cycles after the line-start strobe. The high interval that follows grows by T_ON_NOM/STEPS cycles per line, from 0 up to T_ON_NOM. With the defaults the per-line widths are 0, 4, 8, 12, 16.
- R4: In the running state the drive is low in every cycle in which flyback is high.
- R5: The supply-good input is reported on supply_ok_o one cycle later. While that report is 0, the sequencer holds nominal width without entering the running state, so flyback does not mask the drive.
- R6: When protection-disable is 1 and over-voltage is seen while the drive is ramping up or running, standby-enable is cleared. The ON width then falls by one step per line (16, 12, 8, 4, 0 with the defaults) and the drive stops.
- R7: When protection-disable is 0, over-voltage sets the over-voltage flag, and both the drive and standby-enable continue unchanged.
- R8: The over-voltage flag stays set until a write with bit 3 at 1. While the flag is set, setting standby-enable does not start the drive.
- R9: While flash is high the drive output is low in the same cycle. After flash falls, the drive restarts from zero width through the upward ramp.
- R10: A write loads standby-enable from bit 0 and protection-disable from bit 1. A 1 in bit 2 clears the power-on flag, and a 1 in bit 3 clears the over-voltage flag. A 0 in bit 2 or bit 3 leaves that flag unchanged.
- R11: Clearing standby-enable through a write while the drive is ramping up or running starts the downward ramp (16, 12, 8, 4, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| flyback | input | 1 | Flyback pulse; masks the drive in the running state |
| ovp_in | input | 1 | Over-voltage detected |
| flash_in | input | 1 | Flash protection active |
| supply_good | input | 1 | Main supply present |
| reg_wr | input | 1 | Control write strobe |
| reg_wdata | input | 4 | Control write data |
| hdrv | output | 1 | Horizontal drive pulse |
| stb_en_o | output | 1 | Standby-enable bit |
| prot_dis_o | output | 1 | Protection-disable bit |
| por_flag_o | output | 1 | Sticky power-on flag |
| xray_flag_o | output | 1 | Sticky over-voltage flag |
| supply_ok_o | output | 1 | Registered supply-good status |

## Verification
A wrong step count or a wrong state appears at the next line-start strobe as a per-line ON width that is off by a multiple of T_ON_NOM/STEPS. The reference model compares the drive pin in every cycle, so that error is reported within one line. A wrong state also changes the flyback masking, and that shows in the first cycle of flyback. Flag and control-bit errors appear on their status pins one cycle after the write or protection event that caused them.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;

    typedef enum logic [2:0] {
        HS_IDLE       = 3'd0,
        HS_SOFT_START = 3'd1,
        HS_RUN        = 3'd2,
        HS_SOFT_STOP  = 3'd3,
        HS_FLASH_OFF  = 3'd4
    } hdrv_state_e;

    localparam int CTL_W        = 4;
    localparam int CTL_STB      = 0;
    localparam int CTL_PRD      = 1;
    localparam int CTL_CLR_POR  = 2;
    localparam int CTL_CLR_XRAY = 3;

    typedef struct packed {
        logic stb_en;
        logic prot_dis;
        logic por;
        logic xray;
        logic supply_ok;
    } hdrv_status_t;

    // ON width for a ramp position, scaled linearly to the nominal width
    function automatic int on_width(input int step, input int steps, input int nom);
        return (nom * step) / steps;
    endfunction

    function automatic logic drive_active(input hdrv_state_e s);
        return (s == HS_SOFT_START) || (s == HS_RUN) || (s == HS_SOFT_STOP);
    endfunction

endpackage

// File: rtl/hdrv_regs.sv
module hdrv_regs
    import hdrv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [CTL_W-1:0]     reg_wdata,
    input  logic                 ovp_in,
    input  logic                 supply_good,
    output hdrv_status_t         stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.stb_en    <= 1'b0;
            stat.prot_dis  <= 1'b0;
            stat.por       <= 1'b1;
            stat.xray      <= 1'b0;
            stat.supply_ok <= 1'b0;
        end else begin
            if (reg_wr) begin
                stat.stb_en   <= reg_wdata[CTL_STB];
                stat.prot_dis <= reg_wdata[CTL_PRD];
                if (reg_wdata[CTL_CLR_POR]) begin
                    stat.por <= 1'b0;
                end
            end
            // protection shutdown overrides a simultaneous software enable
            if (ovp_in && stat.prot_dis) begin
                stat.stb_en <= 1'b0;
            end
            if (ovp_in) begin
                stat.xray <= 1'b1;
            end else if (reg_wr && reg_wdata[CTL_CLR_XRAY]) begin
                stat.xray <= 1'b0;
            end
            stat.supply_ok <= supply_good;
        end
    end

endmodule

// File: rtl/hdrv_seq.sv
module hdrv_seq
    import hdrv_pkg::*;
#(
    parameter int STEPS  = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              flash_in,
    input  logic              ovp_in,
    input  hdrv_status_t      stat,
    output hdrv_state_e       st_q,
    output logic [STEP_W-1:0] step_q
);

    localparam logic [STEP_W-1:0] STEP_TOP = STEP_W'(STEPS);

    hdrv_state_e       st_d;
    logic [STEP_W-1:0] step_d;
    logic              may_start;
    logic              must_stop;

    assign may_start = stat.stb_en && !stat.por && !stat.xray && !flash_in;
    assign must_stop = (ovp_in && stat.prot_dis) || !stat.stb_en;

    always_comb begin
        st_d   = st_q;
        step_d = step_q;
        if (flash_in && drive_active(st_q)) begin
            st_d   = HS_FLASH_OFF;
            step_d = '0;
        end else begin
            unique case (st_q)
                HS_IDLE: begin
                    if (may_start) begin
                        st_d = HS_SOFT_START;
                    end
                end
                HS_SOFT_START, HS_RUN: begin
                    if (must_stop) begin
                        st_d = HS_SOFT_STOP;
                    end else if (st_q == HS_SOFT_START && line_start) begin
                        if (step_q < STEP_TOP) begin
                            step_d = step_q + 1'b1;
                        end else if (stat.supply_ok) begin
                            st_d = HS_RUN;
                        end
                    end
                end
                HS_SOFT_STOP: begin
                    if (line_start) begin
                        if (step_q != '0) begin
                            step_d = step_q - 1'b1;
                        end else begin
                            st_d = HS_IDLE;
                        end
                    end
                end
                HS_FLASH_OFF: begin
                    if (!flash_in) begin
                        st_d = stat.stb_en ? HS_SOFT_START : HS_IDLE;
                    end
                end
                default: begin
                    st_d   = HS_IDLE;
                    step_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= HS_IDLE;
            step_q <= '0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/hdrv_pulse.sv
module hdrv_pulse
    import hdrv_pkg::*;
#(
    parameter int T_OFF    = 8,
    parameter int T_ON_NOM = 16,
    parameter int STEPS    = 4,
    parameter int STEP_W   = 3,
    parameter int POS_W    = 8,
    parameter int TON_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              flyback,
    input  logic              flash_in,
    input  hdrv_state_e       st_q,
    input  logic [STEP_W-1:0] step_q,
    output logic              hdrv
);

    logic [POS_W-1:0] pos_q;
    logic [TON_W-1:0] ton_q;
    logic [TON_W-1:0] ton_sel;
    logic [POS_W:0]   win_lo;
    logic [POS_W:0]   win_hi;
    logic             in_win;
    logic             gated;

    assign ton_sel = TON_W'(on_width(int'(step_q), STEPS, T_ON_NOM));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            ton_q <= '0;
        end else begin
            if (line_start) begin
                pos_q <= '0;
            end else if (pos_q != {POS_W{1'b1}}) begin
                pos_q <= pos_q + 1'b1;
            end
            if (st_q == HS_IDLE || st_q == HS_FLASH_OFF) begin
                ton_q <= '0;
            end else if (line_start) begin
                ton_q <= ton_sel;
            end
        end
    end

    assign win_lo = (POS_W+1)'(T_OFF);
    assign win_hi = win_lo + (POS_W+1)'(ton_q);
    assign in_win = ({1'b0, pos_q} >= win_lo) && ({1'b0, pos_q} < win_hi);
    assign gated  = (st_q == HS_RUN) && flyback;
    assign hdrv   = drive_active(st_q) && in_win && !gated && !flash_in;

endmodule

// File: rtl/hdrv_softstart.sv
module hdrv_softstart
    import hdrv_pkg::*;
#(
    parameter int T_OFF    = 8,
    parameter int T_ON_NOM = 16,
    parameter int STEPS    = 4,
    parameter int POS_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             flyback,
    input  logic             ovp_in,
    input  logic             flash_in,
    input  logic             supply_good,
    input  logic             reg_wr,
    input  logic [3:0]       reg_wdata,
    output logic             hdrv,
    output logic             stb_en_o,
    output logic             prot_dis_o,
    output logic             por_flag_o,
    output logic             xray_flag_o,
    output logic             supply_ok_o
);

    localparam int STEP_W = $clog2(STEPS + 1);
    localparam int TON_W  = $clog2(T_ON_NOM + 1);

    hdrv_status_t      stat;
    hdrv_state_e       st_q;
    logic [STEP_W-1:0] step_q;

    hdrv_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .ovp_in      (ovp_in),
        .supply_good (supply_good),
        .stat        (stat)
    );

    hdrv_seq #(
        .STEPS  (STEPS),
        .STEP_W (STEP_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .flash_in   (flash_in),
        .ovp_in     (ovp_in),
        .stat       (stat),
        .st_q       (st_q),
        .step_q     (step_q)
    );

    hdrv_pulse #(
        .T_OFF    (T_OFF),
        .T_ON_NOM (T_ON_NOM),
        .STEPS    (STEPS),
        .STEP_W   (STEP_W),
        .POS_W    (POS_W),
        .TON_W    (TON_W)
    ) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .flyback    (flyback),
        .flash_in   (flash_in),
        .st_q       (st_q),
        .step_q     (step_q),
        .hdrv       (hdrv)
    );

    assign stb_en_o    = stat.stb_en;
    assign prot_dis_o  = stat.prot_dis;
    assign por_flag_o  = stat.por;
    assign xray_flag_o = stat.xray;
    assign supply_ok_o = stat.supply_ok;

endmodule

// File: rtl/hdrv_softstart_chk.sv
module hdrv_softstart_chk
    import hdrv_pkg::*;
#(
    parameter int STEPS  = 4,
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              line_start,
    input logic              flyback,
    input logic              ovp_in,
    input logic              flash_in,
    input logic              reg_wr,
    input logic [3:0]        reg_wdata,
    input logic              hdrv,
    input logic              stb_en,
    input logic              prot_dis,
    input logic              por_flag,
    input logic              xray_flag,
    input logic              supply_ok,
    input hdrv_state_e       st,
    input logic [STEP_W-1:0] step
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (por_flag && !xray_flag && !stb_en && !prot_dis && st == HS_IDLE));

    p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (st == HS_IDLE && (por_flag || xray_flag || !stb_en)) |=> (st == HS_IDLE));

    p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(step) <= STEPS));

    p_step_single_r3: assert property (@(posedge clk) disable iff (rst)
        (st == HS_SOFT_START && !flash_in && stb_en && !(ovp_in && prot_dis))
        |=> (step == $past(step) || step == $past(step) + 1'b1));

    p_flyback_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (st == HS_RUN && flyback) |-> !hdrv);

    p_supply_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st == HS_SOFT_START && !supply_ok) |=> (st != HS_RUN));

    p_ovp_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (ovp_in && prot_dis && !flash_in && (st == HS_SOFT_START || st == HS_RUN))
        |=> (st == HS_SOFT_STOP && !stb_en));

    p_ovp_flag_r7: assert property (@(posedge clk) disable iff (rst)
        ovp_in |=> xray_flag);

    p_xray_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (xray_flag && !(reg_wr && reg_wdata[3])) |=> xray_flag);

    p_flash_cut_r9: assert property (@(posedge clk) disable iff (rst)
        flash_in |-> !hdrv);

    p_stop_by_sw_r11: assert property (@(posedge clk) disable iff (rst)
        (!stb_en && !flash_in && (st == HS_SOFT_START || st == HS_RUN)) |=> (st == HS_SOFT_STOP));

    p_stop_ramp_r6: assert property (@(posedge clk) disable iff (rst)
        (st == HS_SOFT_STOP && line_start && step != '0) |=> (step == $past(step) - 1'b1));

endmodule

bind hdrv_softstart hdrv_softstart_chk #(
    .STEPS  (STEPS),
    .STEP_W (STEP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .flyback    (flyback),
    .ovp_in     (ovp_in),
    .flash_in   (flash_in),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .hdrv       (hdrv),
    .stb_en     (stb_en_o),
    .prot_dis   (prot_dis_o),
    .por_flag   (por_flag_o),
    .xray_flag  (xray_flag_o),
    .supply_ok  (supply_ok_o),
    .st         (st_q),
    .step       (step_q)
);

// File: tb/tb_hdrv_softstart.sv
`timescale 1ns/1ps
module tb_hdrv_softstart;

    localparam int T_OFF = 8;
    localparam int T_ON  = 16;
    localparam int NSTEP = 4;
    localparam int LINE  = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0, flyback = 1'b0, ovp_in = 1'b0, flash_in = 1'b0;
    logic supply_good = 1'b0, reg_wr = 1'b0;
    logic [3:0] reg_wdata = 4'd0;
    logic hdrv, stb_en_o, prot_dis_o, por_flag_o, xray_flag_o, supply_ok_o;

    int n_run = 0, n_fail = 0;
    string cur_req = "R1";
    bit fb_en = 1'b0, done = 1'b0;

    // reference state: 0 idle, 1 ramp up, 2 run, 3 ramp down, 4 flash off
    int m_st, m_step, m_pos, m_ton, o_st, o_step;
    bit m_stb, m_prd, m_por, m_xray, m_sup, o_stb, o_prd, o_por, o_xray, o_sup;
    int hi_all = 0, ov_all = 0, line_hi = 0;
    int wq[$];

    always #2.5 clk = ~clk;

    hdrv_softstart dut (
        .clk(clk), .rst(rst), .line_start(line_start), .flyback(flyback),
        .ovp_in(ovp_in), .flash_in(flash_in), .supply_good(supply_good),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .hdrv(hdrv),
        .stb_en_o(stb_en_o), .prot_dis_o(prot_dis_o), .por_flag_o(por_flag_o),
        .xray_flag_o(xray_flag_o), .supply_ok_o(supply_ok_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic bit has4(input int a, input int b, input int c, input int d);
        for (int i = 0; i + 3 < wq.size(); i++)
            if (wq[i] == a && wq[i+1] == b && wq[i+2] == c && wq[i+3] == d) return 1'b1;
        return 1'b0;
    endfunction

    // behavioural reference, updated at each edge
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_step = 0; m_pos = 0; m_ton = 0;
            m_stb = 0; m_prd = 0; m_por = 1; m_xray = 0; m_sup = 0;
        end else begin
            o_st = m_st; o_step = m_step;
            o_stb = m_stb; o_prd = m_prd; o_por = m_por; o_xray = m_xray; o_sup = m_sup;
            if (reg_wr) begin
                m_stb = reg_wdata[0];
                m_prd = reg_wdata[1];
                if (reg_wdata[2]) m_por = 0;
            end
            if (ovp_in && o_prd) m_stb = 0;
            if (ovp_in) m_xray = 1;
            else if (reg_wr && reg_wdata[3]) m_xray = 0;
            m_sup = supply_good;
            if (flash_in && o_st >= 1 && o_st <= 3) begin
                m_st = 4; m_step = 0;
            end else begin
                case (o_st)
                    0: if (o_stb && !o_por && !o_xray && !flash_in) m_st = 1;
                    1, 2: begin
                        if ((ovp_in && o_prd) || !o_stb) m_st = 3;
                        else if (o_st == 1 && line_start) begin
                            if (o_step < NSTEP) m_step = o_step + 1;
                            else if (o_sup) m_st = 2;
                        end
                    end
                    3: if (line_start) begin
                        if (o_step > 0) m_step = o_step - 1;
                        else m_st = 0;
                    end
                    default: if (!flash_in) m_st = o_stb ? 1 : 0;
                endcase
            end
            if (line_start) m_pos = 0;
            else if (m_pos < 255) m_pos++;
            if (o_st == 0 || o_st == 4) m_ton = 0;
            else if (line_start) m_ton = (T_ON * o_step) / NSTEP;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            bit exp_h;
            exp_h = (m_st >= 1 && m_st <= 3) && m_pos >= T_OFF && m_pos < T_OFF + m_ton
                    && !(m_st == 2 && flyback) && !flash_in;
            chk(cur_req, "hdrv", int'(hdrv), int'(exp_h));
            chk(cur_req, "stb_en", int'(stb_en_o), int'(m_stb));
            chk(cur_req, "prot_dis", int'(prot_dis_o), int'(m_prd));
            chk(cur_req, "por_flag", int'(por_flag_o), int'(m_por));
            chk(cur_req, "xray_flag", int'(xray_flag_o), int'(m_xray));
            chk(cur_req, "supply_ok", int'(supply_ok_o), int'(m_sup));
            if (line_start) begin
                wq.push_back(line_hi);
                line_hi = 0;
            end
            if (hdrv) begin
                hi_all++;
                line_hi++;
            end
            if (hdrv && flyback) ov_all++;
        end
    end

    task automatic wr(input logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_ovp();
        @(negedge clk); ovp_in = 1'b1;
        @(negedge clk); ovp_in = 1'b0;
    endtask

    task automatic lines(input int n);
        repeat (n * LINE) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int b_hi, b_ov;
        fork
            begin
                int lc = 0;
                forever begin
                    @(negedge clk);
                    lc = (lc == LINE - 1) ? 0 : lc + 1;
                    line_start = (lc == 0);
                    flyback = fb_en && lc >= T_OFF + 10 && lc <= T_OFF + 13;
                end
            end
        join_none
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1
        chk("R1", "reset hdrv", int'(hdrv), 0);
        chk("R1", "reset por", int'(por_flag_o), 1);
        chk("R1", "reset xray", int'(xray_flag_o), 0);
        chk("R1", "reset stb", int'(stb_en_o), 0);
        // R10: field positions
        cur_req = "R10";
        wr(4'b0011);
        chk("R10", "stb from bit0", int'(stb_en_o), 1);
        chk("R10", "prd from bit1", int'(prot_dis_o), 1);
        chk("R10", "por kept when bit2 is 0", int'(por_flag_o), 1);
        wr(4'b0001);
        chk("R10", "prd cleared", int'(prot_dis_o), 0);
        // R2: power-on flag still set
        cur_req = "R2";
        b_hi = hi_all;
        lines(3);
        chk("R2", "no drive while por set", hi_all - b_hi, 0);
        // R3: ramp with supply low
        cur_req = "R3";
        wq.delete();
        wr(4'b0101);
        chk("R10", "por cleared by bit2", int'(por_flag_o), 0);
        lines(7);
        chk("R3", "ramp widths 4,8,12,16", int'(has4(4, 8, 12, 16)), 1);
        // R5: supply low keeps ungated
        cur_req = "R5";
        fb_en = 1'b1;
        b_ov = ov_all;
        lines(3);
        chk("R5", "ungated before supply", int'(ov_all - b_ov > 0), 1);
        chk("R5", "supply_ok low", int'(supply_ok_o), 0);
        // R4: run, flyback masks drive
        cur_req = "R4";
        supply_good = 1'b1;
        lines(2);
        b_ov = ov_all; b_hi = hi_all;
        lines(3);
        chk("R4", "no drive in flyback", ov_all - b_ov, 0);
        chk("R4", "drive still running", int'(hi_all - b_hi > 0), 1);
        // R7: over-voltage with protection disabled
        cur_req = "R7";
        pulse_ovp();
        chk("R7", "xray set", int'(xray_flag_o), 1);
        chk("R7", "stb kept", int'(stb_en_o), 1);
        b_hi = hi_all;
        lines(2);
        chk("R7", "drive continues", int'(hi_all - b_hi > 0), 1);
        // R8: sticky until bit3
        cur_req = "R8";
        wr(4'b0001);
        chk("R8", "xray sticky", int'(xray_flag_o), 1);
        wr(4'b1001);
        chk("R8", "xray cleared by bit3", int'(xray_flag_o), 0);
        // R9: flash
        cur_req = "R9";
        fb_en = 1'b0;
        @(negedge clk); flash_in = 1'b1;
        b_hi = hi_all;
        repeat (60) @(negedge clk);
        chk("R9", "no drive during flash", hi_all - b_hi, 0);
        wq.delete();
        flash_in = 1'b0;
        lines(7);
        chk("R9", "restart ramp 4,8,12,16", int'(has4(4, 8, 12, 16)), 1);
        // R6: protected shutdown
        cur_req = "R6";
        wr(4'b0011);
        wq.delete();
        pulse_ovp();
        chk("R6", "stb cleared", int'(stb_en_o), 0);
        lines(7);
        chk("R6", "stop widths 12,8,4,0", int'(has4(12, 8, 4, 0)), 1);
        b_hi = hi_all;
        lines(2);
        chk("R6", "drive stopped", hi_all - b_hi, 0);
        // R8: restart blocked while flag set
        cur_req = "R8";
        wr(4'b0011);
        b_hi = hi_all;
        lines(3);
        chk("R8", "no restart with xray set", hi_all - b_hi, 0);
        wr(4'b1001);
        lines(7);
        chk("R8", "restart after clear", int'(hi_all - b_hi > 0), 1);
        // R11: software stop
        cur_req = "R11";
        wq.delete();
        wr(4'b0000);
        lines(7);
        chk("R11", "stop widths 12,8,4,0", int'(has4(12, 8, 4, 0)), 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule